// File: doc/BRIEF.md
# Binary32 Normalise-and-Round Stage

This stage is the last step of a single-precision arithmetic datapath. It takes an unpacked intermediate value and turns it into a packed IEEE-754 binary32 word with the matching exception flags. The intermediate value is a sign, a signed biased exponent and a 32-bit significand whose lower bits act as guard and sticky positions below the final result LSB. The stage left-justifies the significand and scales tiny values into the subnormal range with a sticky right shift. It then rounds in one of four directions, absorbs a carry out of the rounding add, and saturates or overflows to infinity as the rounding direction requires. The upstream operator that produced the value is not part of this block.

The input value is `in_sig × 2^(in_exp − 157)`. A significand with bit 30 set and no lower bits therefore encodes `2^(in_exp − 127)`, so bit 30 is the hidden one and bits 29..7 line up with the 23 fraction bits. The inputs are sampled on a clock edge where `in_valid` is high. The packed result and its flags are registered and appear one cycle later.

Top module: `fp32_norm_round`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_word` and `out_flags` are all zero until the first accepted input.
- R2: A result is registered on the edge where `in_valid` is high and shows on the next cycle with `out_valid` high. In cycles where `in_valid` is low, `out_valid` is low and `out_word`/`out_flags` keep their previous value.
- R3: If `in_exp` is 255 and either `in_sig` is zero or `in_flags` is nonzero, the output is `{in_sign, 8'hFF, in_sig[29:7]}` with the flags unchanged. If `in_exp` is 255 with a nonzero significand and no incoming flags, the value is treated as an ordinary number.
- R4: A zero significand gives a zero of the input sign (`{in_sign, 31'b0}`) with the flags unchanged, whatever the exponent.
- R5: A significand that is not left-justified is normalised first. An exactly representable normal value packs to its IEEE encoding (for example sign 0, exp 127, sig 0x40000000 gives 0x3F800000; exp 157, sig 1 gives the same).
- R6: Values below 2^-126 become subnormals. The bits that the shift drops still count as sticky, so any nonzero remainder affects the rounding.
- R7: Rounding mode 2'b00 rounds to nearest, with ties to the even result.
- R8: Mode 2'b01 rounds toward +infinity, 2'b10 toward -infinity, and 2'b11 toward zero.
- R9: A round-up that carries out of the significand raises the exponent by one (for example 0x7FFFFFC0 at exp 127 rounds to 0x40000000).
- R10: Inexact (flag bit 0) is set whenever the packed result differs from the exact value.
- R11: A result whose exponent field would reach 255 sets overflow (bit 2) and inexact. The word is infinity if the rounding direction moves away from zero for that sign, and the largest finite magnitude (0x7F7FFFFF with the sign) otherwise.
- R12: Underflow (bit 1) is set only when the exact value is below 2^-126 before rounding and the result is inexact.
- R13: `out_flags` is the bitwise OR of `in_flags` with the flags this stage raises. The flag vector is {invalid, divide-by-zero, overflow, underflow, inexact}, from bit 4 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the inputs on this edge |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | 10 | Signed biased exponent (two's complement) |
| in_sig | input | 32 | Significand with guard bits, hidden one at bit 30 |
| in_rmode | input | 2 | 00 nearest-even, 01 up, 10 down, 11 toward zero |
| in_flags | input | 5 | Flags raised upstream |
| out_valid | output | 1 | Result valid |
| out_word | output | 32 | Packed binary32 result |
| out_flags | output | 5 | {invalid, div-zero, overflow, underflow, inexact} |

## Verification
The rounding carry and the overflow decision can fall in the same cycle. This happens when the largest finite significand plus a half-ULP guard pattern is presented at the top exponent: nearest mode must carry into an infinite result with overflow and inexact, while toward-zero mode on the same input must give the largest finite value with only inexact set. Subnormal scaling and rounding also meet in one cycle. A value just below 2^-126 that rounds up to the smallest normal must still raise underflow, and the bench checks this against an independent integer model of IEEE rounding. That model also runs over a seeded sweep of exponents and significands.

// File: rtl/fnr_pkg.sv
package fnr_pkg;
  // rounding direction encoding
  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_UP   = 2'b01,
    RND_DOWN = 2'b10,
    RND_ZERO = 2'b11
  } rnd_mode_e;

  // flag vector layout
  localparam int FLAG_W      = 5;
  localparam int IDX_INVALID = 4;
  localparam int IDX_DIVZERO = 3;
  localparam int IDX_OVER    = 2;
  localparam int IDX_UNDER   = 1;
  localparam int IDX_INEXACT = 0;

  // packed exponent field width
  localparam int EXPF_W = 8;
endpackage

// File: rtl/fnr_lzc.sv
// Leading-zero count; returns W for an all-zero input.
module fnr_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] zeros
);
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fnr_jam_shift.sv
// Right shift that ORs every bit shifted out into the result LSB.
module fnr_jam_shift #(
  parameter int W  = 32,
  parameter int AW = 11
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [2*W-1:0] wide;
  logic           lost;

  always_comb begin
    wide = {din, {W{1'b0}}} >> amt;
    lost = |wide[W-1:0];
    if (amt >= AW'(W)) begin
      dout = {{(W-1){1'b0}}, |din};
    end else begin
      dout = wide[2*W-1:W] | {{(W-1){1'b0}}, lost};
    end
  end
endmodule

// File: rtl/fnr_round.sv
// Rounding increment, carry fix-up, range check and packing of the magnitude.
module fnr_round
  import fnr_pkg::*;
#(
  parameter int SIG_W   = 32,
  parameter int GUARD_W = 7,
  parameter int E_W     = 11,
  parameter int MAG_W   = EXPF_W + SIG_W - GUARD_W - 2
) (
  input  logic                  sign,
  input  logic signed [E_W-1:0] exp_in,
  input  logic [SIG_W-1:0]      sig_in,
  input  logic [1:0]            mode,
  output logic [MAG_W-1:0]      mag,
  output logic                  ovf,
  output logic                  unf,
  output logic                  inx
);
  localparam int RB     = GUARD_W + 1;            // bits below the result LSB
  localparam int FRAC_W = SIG_W - RB - 1;
  localparam int OVF_E  = (1 << EXPF_W) - 2;
  localparam logic [SIG_W-1:0] HALF   = SIG_W'(1) << (RB - 1);
  localparam logic [SIG_W-1:0] ALL_RB = (SIG_W'(1) << RB) - SIG_W'(1);
  localparam logic [MAG_W-1:0] MAX_FIN = {{(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  localparam logic [MAG_W-1:0] INF_MAG = {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}};

  rnd_mode_e             rmode;
  logic [SIG_W-1:0]      incr;
  logic                  carry;
  logic [SIG_W-1:0]      sig_adj;
  logic [SIG_W-1:0]      sig_fin;
  logic signed [E_W-1:0] exp_adj;
  logic signed [E_W-1:0] exp_fin;
  logic                  tiny_pre;

  assign rmode = rnd_mode_e'(mode);

  // increment selection
  always_comb begin
    case (rmode)
      RND_NEAR: incr = sig_in[RB] ? HALF : HALF - SIG_W'(1);
      RND_UP:   incr = sign ? '0 : ALL_RB;
      RND_DOWN: incr = sign ? ALL_RB : '0;
      default:  incr = '0;
    endcase
  end

  // carry out of the rounding add, fix-up, range check and pack
  always_comb begin
    carry    = sig_in > ~incr;
    tiny_pre = (exp_in == '0) && !sig_in[SIG_W-1];
    if (carry) begin
      exp_adj = exp_in + E_W'(1);
      sig_adj = {1'b0, sig_in[SIG_W-1:1]} | {{(SIG_W-1){1'b0}}, sig_in[0]};
    end else begin
      exp_adj = exp_in;
      sig_adj = sig_in;
    end
    inx     = |sig_adj[RB-1:0];
    sig_fin = sig_adj + incr;
    exp_fin = exp_adj;
    ovf     = 1'b0;
    unf     = 1'b0;
    if (int'(exp_adj) >= OVF_E) begin
      ovf = 1'b1;
      inx = 1'b1;
      mag = (incr == '0) ? MAX_FIN : INF_MAG;
    end else begin
      if ((sig_fin >> RB) == '0) exp_fin = '0;
      unf = inx && tiny_pre;
      mag = (MAG_W'(exp_fin) << FRAC_W) + MAG_W'(sig_fin >> RB);
    end
  end
endmodule

// File: rtl/fp32_norm_round.sv
// Normalise, denormalise, round and pack; one registered stage.
// rst_n is asserted asynchronously; its release is synchronised upstream.
module fp32_norm_round
  import fnr_pkg::*;
#(
  parameter int EXP_W   = 10,
  parameter int SIG_W   = 32,
  parameter int GUARD_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0]        in_sig,
  input  logic [1:0]              in_rmode,
  input  logic [4:0]              in_flags,
  output logic                    out_valid,
  output logic [SIG_W-1:0]        out_word,
  output logic [4:0]              out_flags
);
  localparam int CNT_W  = $clog2(SIG_W) + 1;
  localparam int E_W    = EXP_W + 1;
  localparam int FRAC_W = SIG_W - GUARD_W - 2;
  localparam int MAG_W  = EXPF_W + FRAC_W;

  logic signed [E_W-1:0] exp_ext;
  logic [CNT_W-1:0]      lz;
  logic [SIG_W-1:0]      sig_norm;
  logic signed [E_W-1:0] e_norm;
  logic                  tiny;
  logic [E_W-1:0]        den_amt;
  logic [SIG_W-1:0]      sig_jam;
  logic [SIG_W-1:0]      sig_den;
  logic signed [E_W-1:0] e_den;
  logic [MAG_W-1:0]      rnd_mag;
  logic                  rnd_ovf, rnd_unf, rnd_inx;
  logic                  special, is_zero;
  logic [SIG_W-1:0]      word_d;
  logic [4:0]            flags_d;
  logic                  vld_q;
  logic [SIG_W-1:0]      word_q;
  logic [4:0]            flags_q;

  assign exp_ext = {in_exp[EXP_W-1], in_exp};

  fnr_lzc #(.W(SIG_W), .CW(CNT_W)) u_lzc (
    .din   (in_sig),
    .zeros (lz)
  );

  // left-justify
  always_comb begin
    sig_norm = in_sig << lz;
    e_norm   = exp_ext - $signed({{(E_W-CNT_W){1'b0}}, lz});
    tiny     = e_norm[E_W-1];
    den_amt  = tiny ? E_W'('0 - e_norm) : '0;
  end

  fnr_jam_shift #(.W(SIG_W), .AW(E_W)) u_jam (
    .din  (sig_norm),
    .amt  (den_amt),
    .dout (sig_jam)
  );

  assign sig_den = tiny ? sig_jam : sig_norm;
  assign e_den   = tiny ? '0 : e_norm;

  fnr_round #(.SIG_W(SIG_W), .GUARD_W(GUARD_W), .E_W(E_W), .MAG_W(MAG_W)) u_round (
    .sign   (in_sign),
    .exp_in (e_den),
    .sig_in (sig_den),
    .mode   (in_rmode),
    .mag    (rnd_mag),
    .ovf    (rnd_ovf),
    .unf    (rnd_unf),
    .inx    (rnd_inx)
  );

  // result select
  always_comb begin
    special = (exp_ext == E_W'(255)) && ((in_sig == '0) || (in_flags != '0));
    is_zero = (in_sig == '0);
    if (special) begin
      word_d  = {in_sign, {EXPF_W{1'b1}}, in_sig[SIG_W-3:GUARD_W]};
      flags_d = in_flags;
    end else if (is_zero) begin
      word_d  = {in_sign, {MAG_W{1'b0}}};
      flags_d = in_flags;
    end else begin
      word_d  = {in_sign, rnd_mag};
      flags_d = in_flags;
      flags_d[IDX_OVER]    = in_flags[IDX_OVER]    | rnd_ovf;
      flags_d[IDX_UNDER]   = in_flags[IDX_UNDER]   | rnd_unf;
      flags_d[IDX_INEXACT] = in_flags[IDX_INEXACT] | rnd_inx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      word_q  <= '0;
      flags_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        word_q  <= word_d;
        flags_q <= flags_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;
  assign out_flags = flags_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_flags)));
  // R5
  norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sig != '0) |-> sig_norm[SIG_W-1]);
  // R6
  jam_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tiny && (sig_norm != '0)) |-> (sig_den != '0));
  // R11
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[IDX_OVER] && !$past(in_flags[IDX_OVER]))
      |-> out_flags[IDX_INEXACT]);
  // R12
  unf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[IDX_UNDER] && !$past(in_flags[IDX_UNDER]))
      |-> out_flags[IDX_INEXACT]);
  // R13
  flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_flags & $past(in_flags)) == $past(in_flags)));
  // R3
  special_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && special) |=> (out_word[SIG_W-2 -: EXPF_W] == {EXPF_W{1'b1}}));
endmodule

// File: tb/fp32_norm_round_test.sv
module fp32_norm_round_test;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_sign;
  logic signed [9:0] in_exp;
  logic [31:0]       in_sig;
  logic [1:0]        in_rmode;
  logic [4:0]        in_flags;
  logic              out_valid;
  logic [31:0]       out_word;
  logic [4:0]        out_flags;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  fp32_norm_round uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_rmode(in_rmode), .in_flags(in_flags),
    .out_valid(out_valid), .out_word(out_word), .out_flags(out_flags)
  );

  // independent integer model of binary32 rounding; returns {flags, word}
  function automatic logic [36:0] model(logic s, int e, logic [31:0] sig,
                                        logic [1:0] rm, logic [4:0] fin);
    int p, b, q;
    longint kept, mag;
    logic half, st, inx, up, of, uf;
    if (e == 255 && (sig == 0 || fin != 0)) return {fin, s, 8'hFF, sig[29:7]};
    if (sig == 0) return {fin, s, 31'd0};
    p = 0;
    for (int i = 0; i < 32; i++) if (sig[i]) p = i;
    b = p + e - 30;
    q = (b >= 1) ? p - 23 : 8 - e;
    half = 1'b0; st = 1'b0;
    if (q <= 0) kept = longint'(sig) << (-q);
    else if (q > 32) begin kept = 0; st = 1'b1; end
    else begin
      kept = longint'(sig) >> q;
      half = sig[q-1];
      st = (q > 1) ? ((longint'(sig) & ((64'sd1 << (q-1)) - 1)) != 0) : 1'b0;
    end
    inx = half | st;
    case (rm)
      2'b00:   up = half && (st || kept[0]);
      2'b01:   up = !s && inx;
      2'b10:   up = s && inx;
      default: up = 1'b0;
    endcase
    kept = kept + longint'(up);
    mag = (longint'((b >= 1) ? b - 1 : 0) << 23) + kept;
    of = 1'b0;
    uf = inx && (b < 1);
    if (mag >= 64'sh7F800000) begin
      of = 1'b1; inx = 1'b1; uf = 1'b0;
      mag = (rm == 2'b11 || (rm == 2'b01 && s) || (rm == 2'b10 && !s))
            ? 64'sh7F7FFFFF : 64'sh7F800000;
    end
    return {fin | {2'b00, of, uf, inx}, s, mag[30:0]};
  endfunction

  task automatic chk(string tag, logic [36:0] got, logic [36:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got flags=%h word=%h expected flags=%h word=%h",
               tag, got[36:32], got[31:0], exp[36:32], exp[31:0]);
    end
  endtask

  task automatic run(logic s, int e, logic [31:0] sig, logic [1:0] rm,
                     logic [4:0] fl, output logic [36:0] res);
    @(negedge clk);
    in_sign = s; in_exp = 10'(e); in_sig = sig; in_rmode = rm; in_flags = fl;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    res = {out_flags, out_word};
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {out_flags, out_word}, 37'd0);
    chk("R1 reset valid", {36'd0, out_valid}, 37'd0);
  endtask

  task automatic t_latency();
    logic [36:0] r, hold;
    @(negedge clk);
    in_sign = 0; in_exp = 10'd127; in_sig = 32'h40000000; in_rmode = 0; in_flags = 0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 valid one cycle later", {36'd0, out_valid}, 37'd1);
    hold = {out_flags, out_word};
    chk("R2 result", hold, {5'h00, 32'h3F800000});
    in_sig = 32'h12345678; in_exp = 10'd3; in_flags = 5'h1F;
    @(negedge clk);
    @(negedge clk);
    chk("R2 valid low when idle", {36'd0, out_valid}, 37'd0);
    r = {out_flags, out_word};
    chk("R2 hold while idle", r, hold);
  endtask

  task automatic t_special();
    logic [36:0] r;
    run(1, 255, 32'h0, 2'b00, 5'h00, r);
    chk("R3 infinity passthrough", r, {5'h00, 32'hFF800000});
    run(0, 255, 32'h60000000, 2'b00, 5'h10, r);
    chk("R3 NaN passthrough", r, {5'h10, 32'h7FC00000});
    run(0, 255, 32'h40000000, 2'b00, 5'h00, r);
    chk("R3 exp255 number overflows", r, {5'h05, 32'h7F800000});
  endtask

  task automatic t_zero();
    logic [36:0] r;
    run(1, 50, 32'h0, 2'b01, 5'h08, r);
    chk("R4 negative zero", r, {5'h08, 32'h80000000});
    run(0, -300, 32'h0, 2'b10, 5'h00, r);
    chk("R4 positive zero", r, {5'h00, 32'h00000000});
  endtask

  task automatic t_normalise();
    logic [36:0] r;
    run(0, 157, 32'h00000001, 2'b00, 5'h00, r);
    chk("R5 unnormalised one", r, {5'h00, 32'h3F800000});
    run(1, 128, 32'h60000000, 2'b00, 5'h00, r);
    chk("R5 minus three", r, {5'h00, 32'hC0400000});
    run(0, 1, 32'h40000000, 2'b00, 5'h00, r);
    chk("R5 smallest normal exact", r, {5'h00, 32'h00800000});
  endtask

  task automatic t_nearest();
    logic [36:0] r;
    run(0, 127, 32'h40000040, 2'b00, 5'h00, r);
    chk("R7 tie to even down, R10 inexact", r, {5'h01, 32'h3F800000});
    run(0, 127, 32'h400000C0, 2'b00, 5'h00, r);
    chk("R7 tie to even up", r, {5'h01, 32'h3F800002});
    run(0, 127, 32'h40000041, 2'b00, 5'h00, r);
    chk("R7 above half", r, {5'h01, 32'h3F800001});
  endtask

  task automatic t_directed();
    logic [36:0] r;
    run(0, 127, 32'h40000001, 2'b01, 5'h00, r);
    chk("R8 up positive", r, {5'h01, 32'h3F800001});
    run(1, 127, 32'h40000001, 2'b01, 5'h00, r);
    chk("R8 up negative", r, {5'h01, 32'hBF800000});
    run(1, 127, 32'h40000001, 2'b10, 5'h00, r);
    chk("R8 down negative", r, {5'h01, 32'hBF800001});
    run(0, 127, 32'h4000007F, 2'b11, 5'h00, r);
    chk("R8 toward zero", r, {5'h01, 32'h3F800000});
  endtask

  task automatic t_carry();
    logic [36:0] r;
    run(0, 127, 32'h7FFFFFC0, 2'b00, 5'h00, r);
    chk("R9 carry to next binade", r, {5'h01, 32'h40000000});
    run(0, 127, 32'h7FFFFFC0, 2'b11, 5'h00, r);
    chk("R9 no carry toward zero", r, {5'h01, 32'h3FFFFFFF});
    run(0, 254, 32'h7FFFFFC0, 2'b00, 5'h00, r);
    chk("R9 R11 carry into overflow", r, {5'h05, 32'h7F800000});
    run(0, 254, 32'h7FFFFFC0, 2'b11, 5'h00, r);
    chk("R11 same input toward zero", r, {5'h01, 32'h7F7FFFFF});
  endtask

  task automatic t_tiny();
    logic [36:0] r;
    run(0, -22, 32'h40000000, 2'b00, 5'h00, r);
    chk("R6 R12 exact smallest subnormal", r, {5'h00, 32'h00000001});
    run(0, -23, 32'h40000000, 2'b00, 5'h00, r);
    chk("R6 half subnormal tie to zero", r, {5'h03, 32'h00000000});
    run(0, -23, 32'h40000001, 2'b00, 5'h00, r);
    chk("R6 sticky breaks tie", r, {5'h03, 32'h00000001});
    run(1, -400, 32'h40000000, 2'b10, 5'h00, r);
    chk("R6 deep tiny down negative", r, {5'h03, 32'h80000001});
    run(0, 0, 32'h7FFFFFC0, 2'b00, 5'h00, r);
    chk("R12 rounds up to smallest normal", r, {5'h03, 32'h00800000});
  endtask

  task automatic t_overflow();
    logic [36:0] r;
    run(0, 300, 32'h40000000, 2'b00, 5'h00, r);
    chk("R11 nearest to infinity", r, {5'h05, 32'h7F800000});
    run(0, 300, 32'h40000000, 2'b11, 5'h00, r);
    chk("R11 toward zero saturates", r, {5'h05, 32'h7F7FFFFF});
    run(1, 300, 32'h40000000, 2'b01, 5'h00, r);
    chk("R11 up negative saturates", r, {5'h05, 32'hFF7FFFFF});
    run(1, 300, 32'h40000000, 2'b10, 5'h00, r);
    chk("R11 down negative infinity", r, {5'h05, 32'hFF800000});
    run(0, 254, 32'h7FFFFF80, 2'b00, 5'h00, r);
    chk("R11 largest finite exact", r, {5'h00, 32'h7F7FFFFF});
  endtask

  task automatic t_flags();
    logic [36:0] r;
    run(0, 127, 32'h40000000, 2'b00, 5'h10, r);
    chk("R13 incoming kept exact", r, {5'h10, 32'h3F800000});
    run(0, 127, 32'h40000001, 2'b00, 5'h18, r);
    chk("R13 R10 incoming ORed", r, {5'h19, 32'h3F800000});
  endtask

  task automatic t_sweep();
    logic [36:0] r;
    for (int k = 0; k < 800; k++) begin
      logic s;
      int e;
      logic [31:0] sig;
      logic [1:0] rm;
      logic [4:0] fl;
      s   = 1'($urandom());
      e   = int'($urandom_range(0, 560)) - 280;
      sig = $urandom() >> $urandom_range(0, 31);
      rm  = 2'($urandom());
      fl  = (k % 7 == 0) ? 5'($urandom()) : 5'h00;
      run(s, e, sig, rm, fl, r);
      chk("R5 R6 R7 R8 R10 R12 sweep", r, model(s, e, sig, rm, fl));
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0;
    in_sig = '0; in_rmode = '0; in_flags = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_special();
    t_zero();
    t_normalise();
    t_nearest();
    t_directed();
    t_carry();
    t_tiny();
    t_overflow();
    t_flags();
    t_sweep();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule